// File: doc/BRIEF.md
# Paged GPIO Edge-Interrupt Controller

This block is a 48-line general-purpose I/O controller reached through a small byte-wide register bus. The lines are grouped into six 8-bit data ports. Each port has an output latch that drives the pins. A line whose latch bit is 0 is released and can be read as an input. Reading a data port returns the pin levels after a two-flop synchronizer.

The lines of the first three ports (lines 0 to 23) can also raise edge interrupts. For each such line, an enable bit, a polarity bit and a pending bit sit in three banks. A page register chooses which of these banks appears at the three bank offsets. A pending bit is set by the chosen edge only while the line is enabled. Software acknowledges a pending bit by writing its enable bit to 0 and then back to 1. A summary register shows which ports hold pending edges. A single request output stays high while any pending bit is set.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: After reset, all output latches, enable, polarity and pending bits are 0, the request output is low, and the page register (offset 7) reads 0xC0.
- R2: Writing offset p (0 to 5) loads port p's output latch, which drives pin_drive bits 8p+7..8p, so line n sits at port n/8, bit n%8. Reading offset p returns the synchronized pin levels of those lines.
- R3: With page 0x80, offsets 8, 9 and 10 read and write the enable bytes of ports 0, 1 and 2. With page 0x40, the same offsets read and write the polarity bytes.
- R4: A polarity bit of 1 latches only rising edges on its line, and a polarity bit of 0 latches only falling edges. With page 0xC0, offsets 8 to 10 return the pending bytes of ports 0 to 2.
- R5: An edge that happens while the line's enable bit is 0 is never latched, including after the line is enabled again.
- R6: Lines 24 to 47 never create pending bits, summary bits or requests.
- R7: Offset 6 reads the summary. Bit p (p = 0..2) is 1 when any pending bit of port p is 1, and bits 7:3 read 0.
- R8: Writing an enable bit to 0 clears that line's pending bit on the same clock edge. Writing the bit to 1 again re-arms detection.
- R9: The request output is high while any pending bit is 1. It stays high until the last pending bit is acknowledged.
- R10: Pending bytes are read-only, so writes to offsets 8 to 10 under page 0xC0 have no effect. Offsets 11 to 15 read 0 and ignore writes. Offsets 8 to 10 read 0 under any page value other than 0x80, 0x40 or 0xC0.
- R11: An enabled edge that reaches the detector in the same cycle as the write that sets its enable bit back to 1 is latched, not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset within the 16-byte window |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe; read data is 0 when low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| pin_in | input | 48 | Asynchronous pin levels |
| pin_drive | output | 48 | Output latch bits, one per line |
| irq_out | output | 1 | Interrupt request, OR of all pending bits |

## Verification
The bench walks every interrupt-capable line with alternating polarity. For each line it first applies the wrong edge and then the right one. A detector that ignored the polarity, or used the wrong bit position, would latch on the first edge or light a neighbouring bit. It drives the upper 24 lines hard while all enables are set, which catches a design that decodes interrupts for all six ports. It times a pin edge so that it reaches the detector in the cycle of the re-enable write. A design that masks with the old enable value drops that edge. It also acknowledges one of two pending ports and checks that the request stays high until the second port is acknowledged too.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [7:0] PG_ENABLE   = 8'h80;
  localparam logic [7:0] PG_POLARITY = 8'h40;
  localparam logic [7:0] PG_PENDING  = 8'hC0;

  // per-bit edge match: pol=1 rising, pol=0 falling
  function automatic logic [7:0] edge_hits(input logic [7:0] pol,
                                           input logic [7:0] now,
                                           input logic [7:0] prev);
    return (pol & now & ~prev) | (~pol & ~now & prev);
  endfunction

  // pending update masked by the enable value that will be held after this edge
  function automatic logic [7:0] next_pending(input logic [7:0] cur,
                                              input logic [7:0] hits,
                                              input logic [7:0] en_next);
    return (cur | hits) & en_next;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 48,
  parameter int EDGE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  raw,
  output logic [WIDTH-1:0]  lvl,
  output logic [EDGE_W-1:0] lvl_prev
);
  logic [WIDTH-1:0]  meta_q;
  logic [WIDTH-1:0]  stab_q;
  logic [EDGE_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= raw;
      stab_q <= meta_q;
      hist_q <= stab_q[EDGE_W-1:0];
    end
  end

  assign lvl      = stab_q;
  assign lvl_prev = hist_q;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] lvl_now,
  input  logic [7:0] lvl_prev,
  input  logic       en_wr,
  input  logic       pol_wr,
  input  logic [7:0] wdata,
  output logic [7:0] en_q,
  output logic [7:0] pol_q,
  output logic [7:0] pend_q
);
  logic [7:0] en_next;
  logic [7:0] hit;

  assign en_next = en_wr ? wdata : en_q;
  assign hit     = edge_hits(pol_q, lvl_now, lvl_prev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_next;
      if (pol_wr) pol_q <= wdata;
      pend_q <= next_pending(pend_q, hit, en_next);
    end
  end

  assert_pend_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~en_q) == 8'h00);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> ((pend_q & ~$past(wdata)) == 8'h00));
endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3,
  parameter int ADDR_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic [NUM_PORTS*8-1:0] pin_in,
  output logic [NUM_PORTS*8-1:0] pin_drive,
  output logic                   irq_out
);
  localparam int LINES     = NUM_PORTS * 8;
  localparam int IRQ_LINES = IRQ_PORTS * 8;
  localparam int SUM_OFS   = NUM_PORTS;
  localparam int PAGE_OFS  = NUM_PORTS + 1;
  localparam int BANK_OFS  = NUM_PORTS + 2;

  logic [LINES-1:0]     out_q;
  logic [7:0]           page_q;
  logic [LINES-1:0]     lvl;
  logic [IRQ_LINES-1:0] lvl_prev;
  logic [7:0]           en_all   [IRQ_PORTS];
  logic [7:0]           pol_all  [IRQ_PORTS];
  logic [7:0]           pend_all [IRQ_PORTS];
  logic [IRQ_PORTS-1:0] en_wr;
  logic [IRQ_PORTS-1:0] pol_wr;
  logic [IRQ_PORTS-1:0] summary;
  logic                 any_en_wr;
  logic [7:0]           rd_val;
  int                   idx;

  assign idx = int'(bus_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      page_q <= PG_PENDING;
    end else if (bus_wr) begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (idx == p) out_q[p*8 +: 8] <= bus_wdata;
      if (idx == PAGE_OFS) page_q <= bus_wdata;
    end
  end

  gpio_pin_sync #(.WIDTH(LINES), .EDGE_W(IRQ_LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (pin_in),
    .lvl      (lvl),
    .lvl_prev (lvl_prev)
  );

  for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_port
    assign en_wr[p]  = bus_wr && (idx == BANK_OFS + p) && (page_q == PG_ENABLE);
    assign pol_wr[p] = bus_wr && (idx == BANK_OFS + p) && (page_q == PG_POLARITY);
    gpio_edge_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_now  (lvl[p*8 +: 8]),
      .lvl_prev (lvl_prev[p*8 +: 8]),
      .en_wr    (en_wr[p]),
      .pol_wr   (pol_wr[p]),
      .wdata    (bus_wdata),
      .en_q     (en_all[p]),
      .pol_q    (pol_all[p]),
      .pend_q   (pend_all[p])
    );
    assign summary[p] = |pend_all[p];
  end

  assign any_en_wr = |en_wr;
  assign irq_out   = |summary;
  assign pin_drive = out_q;

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (idx == p) rd_val = lvl[p*8 +: 8];
    if (idx == SUM_OFS)  rd_val[IRQ_PORTS-1:0] = summary;
    if (idx == PAGE_OFS) rd_val = page_q;
    for (int p = 0; p < IRQ_PORTS; p++) begin
      if (idx == BANK_OFS + p) begin
        case (page_q)
          PG_ENABLE:   rd_val = en_all[p];
          PG_POLARITY: rd_val = pol_all[p];
          PG_PENDING:  rd_val = pend_all[p];
          default:     rd_val = '0;
        endcase
      end
    end
  end

  assign bus_rdata = bus_rd ? rd_val : 8'h00;

  assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !any_en_wr) |=> irq_out);

  assert_hole_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx >= BANK_OFS + IRQ_PORTS) |-> (bus_rdata == 8'h00));

  assert_summary_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == SUM_OFS) |-> (bus_rdata[7:IRQ_PORTS] == '0));
endmodule

// File: tb/sim_gpio_edge_irq_ctrl.sv
module sim_gpio_edge_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_drive;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  gpio_edge_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_drive(pin_drive), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = 4'(a); bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_rd(input int a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    rd(a, v);
    chk(v == e, tag, 64'(v), 64'(e));
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq_out == 1'b0, "R1 irq", 64'(irq_out), 0);
    chk(pin_drive == '0, "R1 drive", 64'(pin_drive), 0);
    expect_rd(7, 8'hC0, "R1 page");
    expect_rd(6, 8'h00, "R1 summary");
    wr(7, 8'h80);
    for (int p = 0; p < 3; p++) expect_rd(8 + p, 8'h00, "R1 enable");
    wr(7, 8'h40);
    for (int p = 0; p < 3; p++) expect_rd(8 + p, 8'h00, "R1 polarity");

    // R2 output latches and pin readback
    for (int p = 0; p < 6; p++) begin
      logic [7:0] pat;
      pat = 8'((p * 37 + 5) ^ (p << 5));
      wr(p, pat);
      chk(pin_drive[p*8 +: 8] == pat, "R2 drive", 64'(pin_drive), 64'(pat));
      pin_in[p*8 +: 8] = ~pat;
      settle();
      expect_rd(p, ~pat, "R2 readback");
    end
    pin_in = '0;
    settle();

    // R3 enable and polarity banks
    wr(7, 8'h80);
    for (int p = 0; p < 3; p++) wr(8 + p, 8'(8'h11 * (p + 1)));
    wr(7, 8'h40);
    for (int p = 0; p < 3; p++) wr(8 + p, 8'(8'h5A + p));
    wr(7, 8'h80);
    for (int p = 0; p < 3; p++) expect_rd(8 + p, 8'(8'h11 * (p + 1)), "R3 enable");
    wr(7, 8'h40);
    for (int p = 0; p < 3; p++) expect_rd(8 + p, 8'(8'h5A + p), "R3 polarity");

    // R10 read-only pending, holes, unknown page
    wr(7, 8'hC0);
    wr(8, 8'hFF);
    expect_rd(8, 8'h00, "R10 pending write ignored");
    for (int a = 11; a < 16; a++) begin
      wr(a, 8'hFF);
      expect_rd(a, 8'h00, "R10 hole");
    end
    for (int p = 0; p < 6; p++) expect_rd(p, 8'h00, "R10 hole write leaves data ports");
    wr(7, 8'h80);
    expect_rd(8, 8'h11, "R10 enable unchanged by pending write");
    wr(7, 8'h00);
    expect_rd(9, 8'h00, "R10 unknown page");

    // clear enables, polarity AA: odd bits rising, even bits falling
    wr(7, 8'h80);
    for (int p = 0; p < 3; p++) wr(8 + p, 8'h00);
    wr(7, 8'h40);
    for (int p = 0; p < 3; p++) wr(8 + p, 8'hAA);

    // R4 R7 R8 R9 sweep over every interrupt line
    for (int n = 0; n < 24; n++) begin
      int p, b;
      bit rising;
      p = n / 8; b = n % 8; rising = (b % 2) == 1;
      pin_in[n] = rising;
      settle();
      wr(7, 8'h80);
      wr(8 + p, 8'(1 << b));
      wr(7, 8'hC0);
      pin_in[n] = !rising;
      settle();
      expect_rd(8 + p, 8'h00, "R4 wrong edge");
      pin_in[n] = rising;
      settle();
      expect_rd(8 + p, 8'(1 << b), "R4 right edge");
      expect_rd(6, 8'(1 << p), "R7 summary");
      chk(irq_out == 1'b1, "R9 irq set", 64'(irq_out), 1);
      wr(7, 8'h80);
      wr(8 + p, 8'h00);
      chk(irq_out == 1'b0, "R8 ack clears", 64'(irq_out), 0);
      wr(7, 8'hC0);
      expect_rd(8 + p, 8'h00, "R8 pending cleared");
      pin_in[n] = 1'b0;
      settle();
    end

    // R5 edge while disabled is forgotten (line 3, rising)
    pin_in[3] = 1'b1; settle();
    pin_in[3] = 1'b0; settle();
    pin_in[3] = 1'b1; settle();
    wr(7, 8'h80);
    wr(8, 8'h08);
    wr(7, 8'hC0);
    expect_rd(8, 8'h00, "R5 disabled edge");
    chk(irq_out == 1'b0, "R5 irq", 64'(irq_out), 0);
    wr(7, 8'h80);
    wr(8, 8'h00);
    pin_in[3] = 1'b0; settle();

    // R6 upper lines never interrupt
    for (int p = 0; p < 3; p++) wr(8 + p, 8'hFF);
    pin_in[47:24] = '1; settle();
    pin_in[47:24] = '0; settle();
    pin_in[47:24] = 24'hA5C3F0; settle();
    wr(7, 8'hC0);
    for (int p = 0; p < 3; p++) expect_rd(8 + p, 8'h00, "R6 pending");
    expect_rd(6, 8'h00, "R6 summary");
    chk(irq_out == 1'b0, "R6 irq", 64'(irq_out), 0);
    wr(7, 8'h80);
    for (int p = 0; p < 3; p++) wr(8 + p, 8'h00);
    pin_in = '0; settle();

    // R9 two ports pending, partial acknowledge
    wr(8, 8'h02);
    wr(9, 8'h02);
    pin_in[1] = 1'b1; pin_in[9] = 1'b1;
    settle();
    expect_rd(6, 8'h03, "R7 two ports");
    wr(8, 8'h00);
    wr(8, 8'h02);
    chk(irq_out == 1'b1, "R9 still pending", 64'(irq_out), 1);
    expect_rd(6, 8'h02, "R7 one port left");
    wr(9, 8'h00);
    chk(irq_out == 1'b0, "R9 all acked", 64'(irq_out), 0);
    wr(8, 8'h00);
    pin_in = '0; settle();

    // R11 edge reaches detector in the re-enable write cycle (line 5, rising)
    @(negedge clk);
    pin_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 4'd8; bus_wdata = 8'h20; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    wr(7, 8'hC0);
    expect_rd(8, 8'h20, "R11 coincident edge");
    chk(irq_out == 1'b1, "R11 irq", 64'(irq_out), 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule